// File: doc/BRIEF.md
# Serial port register and interrupt interface

This block is the register front end of a serial port. A host on a simple 32-bit bus with separate read and write strobes and a word index address reaches a small set of control registers, a status word that also carries the last received byte, and an interrupt block with raw, mask, acknowledge and masked views. Bit-level serialisation lives elsewhere. On its serial-facing side the block emits one strobe per byte written for transmit, accepts one strobe per received byte, and raises a receive-ready level.

Writing the data-out word hands its low byte to the transmitter and flags a transmit interrupt. An arriving byte lands in the status word, sets a data-available flag and flags a receive interrupt. Software clears interrupt bits by writing ones to the acknowledge word, which never holds a value. The status word has two read addresses: one consumes data-available as a side effect and one only peeks. A single level interrupt output is the OR of the enabled pending bits.

Top module: `ser_regif`

## Requirements
- R1: After reset, a read of word 9 (byte offset 0x24) returns 0x0140_0000, with bit 24 for transmitter ready and bit 22 for transmitter idle. Every other register is zero, irq_o is 0, tx_valid_o is 0 and rx_ready_o is 1.
- R2: Words 0, 1, 2, 7 and 11 (byte offsets 0x00, 0x04, 0x08, 0x1C, 0x2C) store the full 32-bit written value. A read strobe returns the selected word on rdata_o one clock later.
- R3: A read of word 8 (0x20) returns the status word and clears bit 16, data available, in the same clock. A read of word 9 (0x24) returns the same word and leaves it unchanged.
- R4: A write to word 7 makes tx_valid_o high for exactly the next cycle, with tx_data_o equal to the low byte written. It also sets raw interrupt bit 0.
- R5: A received byte (rx_valid_i) replaces status bits 7:0 and sets status bit 16 and raw interrupt bit 3. All of these are visible on the next cycle.
- R6: Writing word 12 (0x30) clears every raw interrupt bit (word 13, 0x34) that is one in the written value. Word 12 always reads as zero.
- R7: Word 14 (0x38) reads raw AND mask. irq_o is high exactly when that value is nonzero, and it follows the register update that caused the change by one cycle.
- R8: rx_ready_o is high when bit 0 of word 2 is set or when raw interrupt bit 3 is clear.
- R9: When a register write or a status read occurs in the same cycle as a received byte, the byte's updates are applied after the access. An acknowledge of bit 3 therefore leaves bit 3 set, and a clearing read leaves data available set.
- R10: Writes to words 8, 9, 13 and 14, and to unmapped words (3 to 6, 10, 15), change no register. Reads of unmapped words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Word index (byte offset divided by 4) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid one cycle after rd_i |
| irq_o | output | 1 | Level interrupt |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| rx_valid_i | input | 1 | Receive byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receiver can take a byte |

## Verification
A raw interrupt bit stuck at a wrong value appears on the next cycle in three places: the raw word read, irq_o when that bit is enabled, and rx_ready_o when bit 3 is involved. A lost or extra data-available flag shows on the very next peek read of word 9, without consuming it. The same-cycle collisions of a received byte with an acknowledge or with a clearing read are driven on purpose, because a wrong ordering there loses an event silently and only the next read shows it.

// File: rtl/ser_regif_pkg.sv
package ser_regif_pkg;
  localparam int AW = 4;

  typedef enum logic [AW-1:0] {
    OFS_TX_CTRL   = 4'h0,
    OFS_TX_DMA    = 4'h1,
    OFS_RX_CTRL   = 4'h2,
    OFS_DOUT      = 4'h7,
    OFS_STAT_CLR  = 4'h8,
    OFS_STAT_PEEK = 4'h9,
    OFS_IRQ_MASK  = 4'hB,
    OFS_IRQ_ACK   = 4'hC,
    OFS_IRQ_RAW   = 4'hD,
    OFS_IRQ_MSKD  = 4'hE
  } reg_ofs_e;

  localparam int DAV_BIT     = 16;
  localparam int TX_IDLE_BIT = 22;
  localparam int TX_RDY_BIT  = 24;
  localparam int TX_IRQ_BIT  = 0;
  localparam int RX_IRQ_BIT  = 3;

  localparam int N_PLAIN = 4;
  localparam int IDX_TX_CTRL = 0;
  localparam int IDX_TX_DMA  = 1;
  localparam int IDX_RX_CTRL = 2;
  localparam int IDX_DOUT    = 3;
endpackage

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
  import ser_regif_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_clr_i,
  input  logic          rx_i,
  input  logic [BW-1:0] rx_data_i,
  output logic [DW-1:0] stat_o
);
  logic [BW-1:0] byte_q;
  logic          dav_q;

  // rx applied after the clearing read so a colliding byte is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      dav_q  <= 1'b0;
    end else if (rx_i) begin
      byte_q <= rx_data_i;
      dav_q  <= 1'b1;
    end else if (rd_clr_i) begin
      dav_q  <= 1'b0;
    end
  end

  always_comb begin
    stat_o              = '0;
    stat_o[BW-1:0]      = byte_q;
    stat_o[DAV_BIT]     = dav_q;
    stat_o[TX_IDLE_BIT] = 1'b1;
    stat_o[TX_RDY_BIT]  = 1'b1;
  end

  a_r3_clear_dav: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !rx_i) |=> !stat_o[DAV_BIT]);
  a_r5_rx_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_i |=> (stat_o[DAV_BIT] && stat_o[BW-1:0] == $past(rx_data_i)));
  a_r3_no_clear_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_clr_i && !rx_i) |=> $stable(stat_o));
endmodule

// File: rtl/ser_irq_ctrl.sv
module ser_irq_ctrl
  import ser_regif_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mask_we_i,
  input  logic          ack_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tx_set_i,
  input  logic          rx_set_i,
  output logic [DW-1:0] raw_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] masked_o,
  output logic          irq_o
);
  logic [DW-1:0] raw_q, mask_q, masked_q;
  logic [DW-1:0] raw_acc, raw_n, mask_n;
  logic          irq_q;

  always_comb begin
    raw_acc = raw_q;
    if (tx_set_i) raw_acc[TX_IRQ_BIT] = 1'b1;
    if (ack_we_i) raw_acc = raw_acc & ~wdata_i;
    raw_n = raw_acc;
    if (rx_set_i) raw_n[RX_IRQ_BIT] = 1'b1;
    mask_n = mask_we_i ? wdata_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q    <= '0;
      mask_q   <= '0;
      masked_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      raw_q    <= raw_n;
      mask_q   <= mask_n;
      masked_q <= raw_n & mask_n;
      irq_q    <= |(raw_n & mask_n);
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = masked_q;
  assign irq_o    = irq_q;

  a_r7_masked_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_q == (raw_q & mask_q));
  a_r7_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (masked_q != '0));
  a_r6_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_we_i && !rx_set_i) |=> ((raw_q & $past(wdata_i)) == '0));
  a_r9_rx_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_set_i |=> raw_q[RX_IRQ_BIT]);
  a_r4_tx_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_set_i |=> raw_q[TX_IRQ_BIT]);
endmodule

// File: rtl/ser_rd_mux.sv
module ser_rd_mux
  import ser_regif_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] plain_i [N_PLAIN],
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] raw_i,
  input  logic [DW-1:0] masked_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] sel;
  logic [DW-1:0] rdata_q;

  always_comb begin
    unique case (addr_i)
      OFS_TX_CTRL:   sel = plain_i[IDX_TX_CTRL];
      OFS_TX_DMA:    sel = plain_i[IDX_TX_DMA];
      OFS_RX_CTRL:   sel = plain_i[IDX_RX_CTRL];
      OFS_DOUT:      sel = plain_i[IDX_DOUT];
      OFS_STAT_CLR,
      OFS_STAT_PEEK: sel = stat_i;
      OFS_IRQ_MASK:  sel = mask_i;
      OFS_IRQ_RAW:   sel = raw_i;
      OFS_IRQ_MSKD:  sel = masked_i;
      default:       sel = '0;  // ack and unmapped
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/ser_regif.sv
module ser_regif
  import ser_regif_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          tx_valid_o,
  output logic [BW-1:0] tx_data_o,
  input  logic          rx_valid_i,
  input  logic [BW-1:0] rx_data_i,
  output logic          rx_ready_o
);
  localparam logic [AW-1:0] PLAIN_OFS [N_PLAIN] =
    '{OFS_TX_CTRL, OFS_TX_DMA, OFS_RX_CTRL, OFS_DOUT};

  logic [DW-1:0] plain_q [N_PLAIN];
  logic [DW-1:0] stat, raw, mask, masked;
  logic          dout_we, mask_we, ack_we, rd_clr;
  logic          tx_valid_q;
  logic [BW-1:0] tx_data_q;

  assign dout_we = wr_i && (addr_i == OFS_DOUT);
  assign mask_we = wr_i && (addr_i == OFS_IRQ_MASK);
  assign ack_we  = wr_i && (addr_i == OFS_IRQ_ACK);
  assign rd_clr  = rd_i && (addr_i == OFS_STAT_CLR);

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               plain_q[i] <= '0;
      else if (wr_i && addr_i == PLAIN_OFS[i])   plain_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= dout_we;
      if (dout_we) tx_data_q <= wdata_i[BW-1:0];
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  ser_stat_reg #(.DW(DW), .BW(BW)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_clr_i  (rd_clr),
    .rx_i      (rx_valid_i),
    .rx_data_i (rx_data_i),
    .stat_o    (stat)
  );

  ser_irq_ctrl #(.DW(DW)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (mask_we),
    .ack_we_i  (ack_we),
    .wdata_i   (wdata_i),
    .tx_set_i  (dout_we),
    .rx_set_i  (rx_valid_i),
    .raw_o     (raw),
    .mask_o    (mask),
    .masked_o  (masked),
    .irq_o     (irq_o)
  );

  ser_rd_mux #(.DW(DW)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .plain_i  (plain_q),
    .stat_i   (stat),
    .mask_i   (mask),
    .raw_i    (raw),
    .masked_i (masked),
    .rdata_o  (rdata_o)
  );

  assign rx_ready_o = plain_q[IDX_RX_CTRL][0] | ~raw[RX_IRQ_BIT];

  a_r4_tx_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_we |=> (tx_valid_o && tx_data_o == $past(wdata_i[BW-1:0])));
  a_r4_tx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_we |=> !tx_valid_o);
  a_r8_ready_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw[RX_IRQ_BIT] == 1'b0) |-> rx_ready_o);
endmodule

// File: tb/ser_regif_tb.sv
module ser_regif_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, rx_valid = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  rx_data = '0;
  logic [31:0] rdata;
  logic        irq, tx_valid, rx_ready;
  logic [7:0]  tx_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_regif u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .irq_o(irq), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  ofs;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h24, 32'h0140_0000, 8'd1},  // R1 reset status
    '{1'b1, 8'h34, 32'h0000_0000, 8'd1},  // R1 raw zero
    '{1'b0, 8'h00, 32'hA5A5_1234, 8'd2},  // R2
    '{1'b1, 8'h00, 32'hA5A5_1234, 8'd2},
    '{1'b0, 8'h04, 32'h0000_0001, 8'd2},
    '{1'b1, 8'h04, 32'h0000_0001, 8'd2},
    '{1'b0, 8'h2C, 32'h0000_0009, 8'd2},
    '{1'b1, 8'h2C, 32'h0000_0009, 8'd2},
    '{1'b0, 8'h20, 32'hFFFF_FFFF, 8'd10}, // R10 status read-only
    '{1'b0, 8'h24, 32'h0000_0000, 8'd10},
    '{1'b1, 8'h24, 32'h0140_0000, 8'd10},
    '{1'b0, 8'h34, 32'hFFFF_FFFF, 8'd10}, // raw not writable
    '{1'b1, 8'h34, 32'h0000_0000, 8'd10},
    '{1'b0, 8'h1C, 32'h1234_56C3, 8'd4},  // R4
    '{1'b1, 8'h1C, 32'h1234_56C3, 8'd2},
    '{1'b1, 8'h34, 32'h0000_0001, 8'd4},
    '{1'b1, 8'h38, 32'h0000_0001, 8'd7},  // R7
    '{1'b0, 8'h30, 32'h0000_0001, 8'd6},  // R6
    '{1'b1, 8'h34, 32'h0000_0000, 8'd6},
    '{1'b1, 8'h30, 32'h0000_0000, 8'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    addr = ofs[5:2]; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    addr = ofs[5:2]; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic do_rx(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset outputs
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) begin
        do_rd(VECS[i].ofs, d);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), d, VECS[i].data);
      end else begin
        do_wr(VECS[i].ofs, VECS[i].data);
      end
    end

    // R4 transmit strobe: high one cycle, low byte
    do_wr(8'h1C, 32'h0000_00EE);
    chk("R4 tx_valid", {31'b0, tx_valid}, 32'd1);
    chk("R4 tx_data", {24'b0, tx_data}, 32'h0000_00EE);
    @(negedge clk);
    chk("R4 tx_valid single", {31'b0, tx_valid}, 32'd0);
    chk("R7 irq tx", {31'b0, irq}, 32'd1);
    do_wr(8'h30, 32'h0000_0001);
    chk("R7 irq cleared", {31'b0, irq}, 32'd0);

    // R10 unmapped
    do_wr(8'h3C, 32'hFFFF_FFFF);
    do_wr(8'h10, 32'hFFFF_FFFF);
    do_rd(8'h3C, d); chk("R10 unmapped 3C", d, 32'd0);
    do_rd(8'h10, d); chk("R10 unmapped 10", d, 32'd0);
    do_rd(8'h2C, d); chk("R10 mask kept", d, 32'h9);

    // R5 receive
    do_rx(8'h5A);
    chk("R7 irq rx", {31'b0, irq}, 32'd1);
    chk("R8 rx_ready low", {31'b0, rx_ready}, 32'd0);
    do_rd(8'h24, d); chk("R5 status", d, 32'h0141_005A);
    do_rd(8'h34, d); chk("R5 raw bit3", d, 32'h8);

    // R8 enable bit overrides
    do_wr(8'h08, 32'h1);
    chk("R8 rx_ready enabled", {31'b0, rx_ready}, 32'd1);
    do_wr(8'h08, 32'h0);
    chk("R8 rx_ready disabled", {31'b0, rx_ready}, 32'd0);

    // R3 clearing vs peek
    do_rd(8'h20, d); chk("R3 clr read", d, 32'h0141_005A);
    do_rd(8'h24, d); chk("R3 dav cleared", d, 32'h0140_005A);
    do_rd(8'h24, d); chk("R3 peek stable", d, 32'h0140_005A);

    // R9 ack of bit 3 colliding with a byte
    @(negedge clk);
    addr = 4'hC; wdata = 32'h8; wr = 1'b1; rx_data = 8'h3C; rx_valid = 1'b1;
    @(negedge clk);
    wr = 1'b0; rx_valid = 1'b0;
    do_rd(8'h34, d); chk("R9 raw bit3 kept", d, 32'h8);
    do_rd(8'h24, d); chk("R9 byte kept", d, 32'h0141_003C);
    do_wr(8'h30, 32'h8);
    do_rd(8'h34, d); chk("R6 raw cleared", d, 32'h0);
    chk("R8 rx_ready after ack", {31'b0, rx_ready}, 32'd1);

    // R9 clearing read colliding with a byte
    @(negedge clk);
    addr = 4'h8; rd = 1'b1; rx_data = 8'h77; rx_valid = 1'b1;
    @(negedge clk);
    rd = 1'b0; rx_valid = 1'b0;
    chk("R9 read old word", rdata, 32'h0141_003C);
    do_rd(8'h24, d); chk("R9 dav kept", d, 32'h0141_0077);

    // R7 masked off
    do_wr(8'h2C, 32'h0);
    chk("R7 irq masked", {31'b0, irq}, 32'd0);
    do_rd(8'h38, d); chk("R7 masked zero", d, 32'h0);
    do_rd(8'h34, d); chk("R7 raw still set", d, 32'h8);
    do_wr(8'h2C, 32'h8);
    chk("R7 irq unmasked", {31'b0, irq}, 32'd1);

    done = 1;
    summary();
  end
endmodule